// File: doc/BRIEF.md
# Room Occupancy Counter with Door Edge Detection

This block tracks how many people are inside a room that has an entry door and an exit door, each watched by a photocell. A photocell level goes high while a person breaks the beam and may stay high for many clock cycles. Each door has its own edge conditioner that turns such a level into a single one-cycle step, so one passage through a door moves the count by at most one.

The occupancy is held in a saturating counter that never drops below zero and never climbs above three. An entry step with no exit step adds one. An exit step with no entry step subtracts one. Entry and exit steps in the same cycle cancel. Two flags report an empty room and a full room, and the count itself is also driven out. The photocell inputs are assumed to be already synchronous to the clock and free of bounce.

Top module: `occupancy_counter`

## Requirements
- R1: A door input that is high for several consecutive sampled cycles causes exactly one step, taken on the first of those cycles; the following high cycles have no effect on the count.
- R2: After a step, a door input produces another step only after it has been sampled low for at least one cycle and then sampled high again.
- R3: An entry step with no exit step while the count is 3 leaves the count at 3.
- R4: An exit step with no entry step while the count is 0 leaves the count at 0.
- R5: An entry step and an exit step in the same cycle leave the count unchanged at every count value, including 0 and 3.
- R6: `empty` is 1 exactly when the count is 0 and `full` is 1 exactly when the count is 3; both follow the count after the update made at the clock edge that sampled the door inputs.
- R7: A synchronous active-high `rst` sets the count to 0 and arms both doors; a door input that is already high on the first sampled cycle after reset counts as a new step.
- R8: `count` is a 2-bit unsigned value equal to the current occupancy, and it changes by at most one per clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| door_in | input | 1 | Entry door photocell level, high while the beam is broken |
| door_out | input | 1 | Exit door photocell level, high while the beam is broken |
| empty | output | 1 | High when the occupancy is 0 |
| full | output | 1 | High when the occupancy is 3 |
| count | output | 2 | Current occupancy, unsigned |

## Verification
The hardest situation to reach is a fresh entry edge and a fresh exit edge in the same cycle while the counter is already at a bound. Both door inputs must first be brought low for a cycle so that both conditioners re-arm, and the count must first be driven to 3 or 0 by a sequence of separated edges. The stimulus does this with explicit low cycles between edges and then raises both inputs together. It also raises both inputs while only one door is armed, so that a single step passes through.

// File: rtl/occupancy_counter.sv
module occupancy_counter #(
  parameter int MAX_OCC = 3,
  localparam int CW = $clog2(MAX_OCC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          door_in,
  input  logic          door_out,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);

  localparam logic [CW-1:0] TOP = CW'(MAX_OCC);

  logic          in_armed, out_armed;
  logic          inc, dec;
  logic [CW-1:0] occ;

  assign inc = door_in & in_armed;
  assign dec = door_out & out_armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_armed  <= 1'b1;
      out_armed <= 1'b1;
    end else begin
      in_armed  <= ~door_in;
      out_armed <= ~door_out;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      occ <= '0;
    else if (inc && !dec && occ != TOP)
      occ <= occ + 1'b1;
    else if (dec && !inc && occ != '0)
      occ <= occ - 1'b1;
  end

  assign count = occ;
  assign empty = (occ == '0);
  assign full  = (occ == TOP);

endmodule

module occupancy_chk #(
  parameter int MAX_OCC = 3,
  localparam int CW = $clog2(MAX_OCC + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          door_in,
  input logic          door_out,
  input logic          empty,
  input logic          full,
  input logic [CW-1:0] count
);

  logic prev_in, prev_out, live;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_in  <= 1'b0;
      prev_out <= 1'b0;
      live     <= 1'b0;
    end else begin
      prev_in  <= door_in;
      prev_out <= door_out;
      live     <= 1'b1;
    end
  end

  // R1
  held_in_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (door_in && prev_in && !door_out) |=> (count <= $past(count)));

  // R3
  full_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (full && door_in && !door_out) |=> full);

  // R4
  empty_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && door_out && !door_in) |=> empty);

  // R5
  both_edges_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (door_in && !prev_in && door_out && !prev_out) |=> $stable(count));

  // R8
  single_step_chk: assert property (@(posedge clk) disable iff (rst || !live)
    (count == $past(count)) || (count == $past(count) + 1'b1) ||
    (count == $past(count) - 1'b1));

endmodule

bind occupancy_counter occupancy_chk #(.MAX_OCC(MAX_OCC)) u_chk (
  .clk(clk), .rst(rst), .door_in(door_in), .door_out(door_out),
  .empty(empty), .full(full), .count(count)
);

// File: tb/occupancy_counter_bench.sv
`timescale 1ns/1ps
module occupancy_counter_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       door_in = 1'b0;
  logic       door_out = 1'b0;
  logic       empty, full;
  logic [1:0] count;

  always #2.5 clk = ~clk;

  occupancy_counter u_occupancy_counter (
    .clk(clk), .rst(rst), .door_in(door_in), .door_out(door_out),
    .empty(empty), .full(full), .count(count)
  );

  typedef struct {
    int    cnt;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   m_cnt = 0;
  bit   m_ai = 1'b1;
  bit   m_ao = 1'b1;
  bit   done = 1'b0;

  task automatic compare(input int cnt, input string tag);
    bit e, f;
    e = (cnt == 0);
    f = (cnt == 3);
    checks++;
    if (int'(count) != cnt || empty !== e || full !== f) begin
      errors++;
      $display("FAIL %s: count=%0d empty=%0b full=%0b, expected count=%0d empty=%0b full=%0b",
               tag, count, empty, full, cnt, e, f);
    end
  endtask

  task automatic step(input bit r, input bit i, input bit o, input string tag);
    exp_t it;
    bit pi, po;
    @(negedge clk);
    rst = r; door_in = i; door_out = o;
    if (r) begin
      m_cnt = 0; m_ai = 1'b1; m_ao = 1'b1;
    end else begin
      pi = i & m_ai;
      po = o & m_ao;
      m_ai = !i;
      m_ao = !o;
      if (pi && !po && m_cnt < 3) m_cnt++;
      else if (po && !pi && m_cnt > 0) m_cnt--;
    end
    it.cnt = m_cnt;
    it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      compare(it.cnt, it.tag);
    end
  end

  initial begin
    #(5.0 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; door_in = 1'b1; door_out = 1'b0;
    repeat (3) @(posedge clk);
    #1 compare(0, "R7 reset state");
    // R7: input high across reset release counts once
    step(0, 1, 0, "R7");
    // R1: held level, no further steps
    step(0, 1, 0, "R1");
    step(0, 1, 0, "R1");
    // R2: re-arm after a low cycle
    step(0, 0, 0, "R2");
    step(0, 1, 0, "R2");
    step(0, 0, 0, "R2");
    step(0, 1, 0, "R6 full");
    // R3: entry at full ignored
    step(0, 0, 0, "R3");
    step(0, 1, 0, "R3");
    // R5: both at full
    step(0, 0, 0, "R5");
    step(0, 1, 1, "R5 at 3");
    // R6 / R8: walk down
    step(0, 0, 0, "R8");
    step(0, 0, 1, "R6");
    step(0, 0, 0, "R8");
    step(0, 0, 1, "R8");
    step(0, 0, 0, "R8");
    step(0, 0, 1, "R6 empty");
    // R4: exit at empty ignored
    step(0, 0, 0, "R4");
    step(0, 0, 1, "R4");
    // R5: both at empty, then held
    step(0, 0, 0, "R5");
    step(0, 1, 1, "R5 at 0");
    step(0, 1, 1, "R1 both held");
    // R5 counterpart: only exit armed, single step passes
    step(0, 0, 0, "R8");
    step(0, 1, 0, "R8");
    step(0, 1, 1, "R1 entry held exit fresh");
    // R5 mid range
    step(0, 0, 0, "R5");
    step(0, 1, 0, "R5");
    step(0, 0, 0, "R5");
    step(0, 1, 1, "R5 at 1");
    // R7: reset mid-run with entry high, then counts again
    step(0, 0, 0, "R7");
    step(0, 1, 0, "R7");
    step(1, 1, 0, "R7 reset clears");
    step(0, 1, 0, "R7 re-armed");
    step(0, 1, 0, "R1");
    step(0, 0, 0, "R7");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule